// File: doc/BRIEF.md
# Fault-Secure Syndrome Error Detector

This block checks 15-bit codewords of a (15,7,5) cyclic low-density parity-check code. It produces the whole 15-bit syndrome and a single error flag. The parity-check matrix is square and redundant, with 15 rows. Each row is a cyclic rotation of a weight-4 pattern, and each row feeds its own private XOR tree, so no gate is shared between syndrome bits. As a result, any error pattern lighter than the code distance drives at least one syndrome bit high. That property also holds when part of the detector logic itself is faulty, because a single faulty tree can only affect its own syndrome bit. The flag is the OR of all syndrome bits. An all-zero syndrome marks a valid codeword.

Words enter on a valid/ready stream and results leave on another valid/ready stream. A parameter sets the output path:

- **Combinational variant:** results pass straight through. Back-pressure is forwarded unchanged, so `in_ready` equals `out_ready`.
- **Registered variant:** one output register holds the result. A word is accepted when `in_valid` and `in_ready` are both high. The result is then presented until the consumer takes it with `out_ready`. The stage accepts a new word whenever it is empty or is being drained in the same cycle.

Top module: `fsd_detector`

## Requirements
- R1: Syndrome bit r (bit 0 = LSB) is the XOR of input word bits at positions (r+0), (r+1), (r+3) and (r+7), each taken modulo 15. Bit 0 of the word is its LSB.
- R2: `out_err` is 1 exactly when at least one bit of `out_syn` is 1.
- R3: The all-zero word, and every word whose syndrome is zero, gives `out_err` = 0.
- R4: Every word of Hamming weight e, for e from 1 to 4, gives `out_err` = 1 and a syndrome with at least 5−e ones.
- R5: With REG_OUT=1, a word accepted on a clock edge shows its result with `out_valid`=1 after that edge. `in_ready` equals (not `out_valid`) or `out_ready`.
- R6: With REG_OUT=1, while `out_valid`=1 and `out_ready`=0, `out_syn` and `out_err` stay unchanged and `out_valid` stays 1.
- R7: With REG_OUT=0, `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and the result corresponds to the current `in_word`, all in the same cycle.
- R8: While `rst_n` is low, and directly after it rises, `out_valid` is 0 in the registered variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | N (15) | Codeword under check |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_syn | output | N (15) | Syndrome vector |
| out_err | output | 1 | Error flag, OR of the syndrome |

## Verification
The bench builds two instances side by side: one with REG_OUT=1 and one with REG_OUT=0, both using the default length of 15 and the weight-4 first row. All 32768 possible input words are fed through both instances under random valid and ready patterns. This reaches every error weight, so the distance bound is checked exhaustively, including the all-zero word and every word with a zero syndrome. The registered instance is exercised under stalls, simultaneous drain-and-refill cycles and idle gaps. The combinational instance is checked for same-cycle pass-through of data and back-pressure.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  localparam int unsigned MAX_LEN = 64;

  // Rotate the low n bits of a row mask left by sh places.
  function automatic logic [MAX_LEN-1:0] rotl_mask(input logic [MAX_LEN-1:0] row,
                                                   input int unsigned sh,
                                                   input int unsigned n);
    logic [MAX_LEN-1:0] o;
    o = '0;
    for (int unsigned j = 0; j < n; j++)
      if (row[j]) o[(j + sh) % n] = 1'b1;
    return o;
  endfunction
endpackage

// File: rtl/fsd_syn_row.sv
// One syndrome bit from a private XOR tree, no gate shared with other rows.
module fsd_syn_row #(
  parameter int unsigned N = 15,
  parameter logic [N-1:0] MASK = '0
) (
  input  logic [N-1:0] word,
  output logic         bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int j = 0; j < N; j++)
      if (MASK[j]) bit_o = bit_o ^ word[j];
  end
endmodule

// File: rtl/fsd_flag_or.sv
module fsd_flag_or #(
  parameter int unsigned N = 15
) (
  input  logic [N-1:0] syn,
  output logic         err
);
  assign err = |syn;
endmodule

// File: rtl/fsd_out_stage.sv
module fsd_out_stage #(
  parameter int unsigned N = 15,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] syn_in,
  input  logic         err_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_syn,
  output logic         out_err
);
  generate
    if (REG_OUT) begin : g_reg
      logic         v_q;
      logic [N-1:0] syn_q;
      logic         err_q;

      assign in_ready = !v_q || out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q   <= 1'b0;
          syn_q <= '0;
          err_q <= 1'b0;
        end else if (in_valid && in_ready) begin
          v_q   <= 1'b1;
          syn_q <= syn_in;
          err_q <= err_in;
        end else if (out_ready) begin
          v_q <= 1'b0;
        end
      end

      assign out_valid = v_q;
      assign out_syn   = syn_q;
      assign out_err   = err_q;

      p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_syn) && $stable(out_err)));
      p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
      p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_syn   = syn_in;
      assign out_err   = err_in;

      p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (out_err == (syn_in != '0)));
    end
  endgenerate
endmodule

// File: rtl/fsd_detector.sv
module fsd_detector #(
  parameter int unsigned  N       = 15,
  parameter logic [N-1:0] ROW0    = 15'h008B,
  parameter int unsigned  DIST    = 5,
  parameter bit           REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_syn,
  output logic         out_err
);
  logic [N-1:0] syn_c;
  logic         err_c;

  for (genvar r = 0; r < N; r++) begin : g_row
    localparam logic [fsd_pkg::MAX_LEN-1:0] ROT =
      fsd_pkg::rotl_mask(fsd_pkg::MAX_LEN'(ROW0), r, N);
    fsd_syn_row #(.N(N), .MASK(ROT[N-1:0])) u_row (
      .word (in_word),
      .bit_o(syn_c[r])
    );
  end

  fsd_flag_or #(.N(N)) u_or (.syn(syn_c), .err(err_c));

  fsd_out_stage #(.N(N), .REG_OUT(REG_OUT)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .syn_in   (syn_c),
    .err_in   (err_c),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_syn  (out_syn),
    .out_err  (out_err)
  );

  p_zero_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word == '0) |-> !err_c);
  p_light_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $countones(in_word) > 0 && $countones(in_word) < DIST) |-> err_c);
  p_syn_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $countones(in_word) > 0 && $countones(in_word) < DIST)
      |-> ($countones(syn_c) >= (DIST - $countones(in_word))));
endmodule

// File: tb/tb_fsd_detector.sv
module tb_fsd_detector;
  localparam int CLK_PERIOD = 10;
  localparam int N = 15;
  localparam int DIST = 5;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         in_valid, out_ready;
  logic [N-1:0] in_word;
  logic         r_in_ready, r_out_valid, r_out_err;
  logic [N-1:0] r_out_syn;
  logic         c_in_ready, c_out_valid, c_out_err;
  logic [N-1:0] c_out_syn;

  fsd_detector #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r_in_ready),
    .in_word(in_word), .out_valid(r_out_valid), .out_ready(out_ready),
    .out_syn(r_out_syn), .out_err(r_out_err));

  fsd_detector #(.REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_word(in_word), .out_valid(c_out_valid), .out_ready(out_ready),
    .out_syn(c_out_syn), .out_err(c_out_err));

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;
  logic [N:0] exp_q[$];

  function automatic logic [N-1:0] syn_ref(input logic [N-1:0] w);
    int offs[4] = '{0, 1, 3, 7};
    logic [N-1:0] s;
    for (int r = 0; r < N; r++) begin
      s[r] = 1'b0;
      foreach (offs[k]) s[r] = s[r] ^ w[(r + offs[k]) % N];
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", LIMIT, 0);
    finish_run();
  end

  initial begin
    int  w = 0;
    bit  held, stalled, exp_rdy;
    logic [N-1:0] ref_s;
    int  wt;
    in_valid = 1'b0; out_ready = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    chk(r_out_valid == 1'b0, "R8 out_valid in reset", r_out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(r_out_valid == 1'b0, "R8 out_valid after reset", r_out_valid, 0);
    stalled = 1'b0;
    while (w <= (1 << N)) begin
      if (exp_q.size() != 0) begin
        chk(r_out_valid == 1'b1, "R5 out_valid set", r_out_valid, 1);
        chk(r_out_syn == exp_q[0][N-1:0], stalled ? "R6 held syndrome" : "R1 reg syndrome",
            r_out_syn, exp_q[0][N-1:0]);
        chk(r_out_err == exp_q[0][N], stalled ? "R6 held flag" : "R2 reg flag",
            r_out_err, exp_q[0][N]);
      end else begin
        chk(r_out_valid == 1'b0, "R5 out_valid clear", r_out_valid, 0);
      end
      if (w == (1 << N)) break;
      held      = (exp_q.size() != 0);
      out_ready = ($urandom % 4) != 0;
      in_valid  = ($urandom % 5) != 0;
      in_word   = N'(w);
      #1;
      exp_rdy = !held || out_ready;
      chk(r_in_ready == exp_rdy, "R5 in_ready", r_in_ready, exp_rdy);
      ref_s = syn_ref(in_word);
      chk(c_out_valid == in_valid, "R7 valid pass", c_out_valid, in_valid);
      chk(c_in_ready == out_ready, "R7 ready pass", c_in_ready, out_ready);
      if (in_valid) begin
        chk(c_out_syn == ref_s, "R1 comb syndrome", c_out_syn, ref_s);
        chk(c_out_err == (ref_s != '0), "R2 comb flag", c_out_err, ref_s != '0);
        wt = $countones(in_word);
        if (ref_s == '0)
          chk(c_out_err == 1'b0, "R3 zero syndrome flag", c_out_err, 0);
        if (wt > 0 && wt < DIST) begin
          chk(c_out_err == 1'b1, "R4 light error flag", c_out_err, 1);
          chk($countones(c_out_syn) >= DIST - wt, "R4 syndrome weight",
              $countones(c_out_syn), DIST - wt);
        end
      end
      stalled = held && !out_ready;
      if (held && out_ready) void'(exp_q.pop_front());
      if (in_valid && exp_rdy) begin
        exp_q.push_back({ref_s != '0, ref_s});
        stalled = 1'b0;
        w++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(r_out_valid == 1'b0, "R5 drained", r_out_valid, 0);
    finish_run();
  end
endmodule